// File: doc/BRIEF.md
# Parallel Branch Event Readout Merger

This block gathers one event from five independent data branches at the same time and writes every word into the memory of one target processor, chosen when the event starts. Each branch offers 16-bit words on a valid/ready handshake and marks its final word of the event with a last flag. A round-robin arbiter grants the single output write port to one branch at a time. Grants are spaced by a fixed slot of clock cycles, so the write port runs faster than any one branch but never faster than its slot rate.

Before an event, each branch gets a base address for its own contiguous region in the target memory. During the event, a per-branch counter steps by one for each word that branch delivers. The event completes when every branch has sent its last word. It cannot be stopped once started, and a new event is refused until the completion flag has been acknowledged.

A host read path forwards reads to any processor that is not the active target. A read aimed at the active target is refused with an error pulse, and the readout carries on unaffected.

Top module: `br_merge`

## Requirements
- R1: `br_ready` has at most one bit set, and only while an event is running. Ready is never given to a branch whose `br_valid` is low or whose `done_mask` bit is set, so words offered after a branch's last word are not taken.
- R2: When several branches are eligible, the grant goes to the first eligible index at or after (last granted index + 1), with indices counted 0..4 and wrapping from 4 back to 0. The pointer starts at index 0 after reset.
- R3: Two grants are at least SLOT_CYC clock cycles apart (default 4). The slot count carries over between events. The first grant after reset may come in the first running cycle.
- R4: One cycle after a handshake, `wr_en` is high for exactly one cycle. In that cycle `wr_data` carries the accepted word and `wr_cpu` carries the event's target. `wr_en` is low in every other cycle.
- R5: `wr_addr` equals the granted branch's base address plus the number of words that branch has already delivered in the current event.
- R6: `cfg_we` loads `cfg_base` as the base of branch `cfg_idx` only while the block is idle. Base writes during a running or completed event are ignored. Counters take the base values when an event starts.
- R7: A word with `br_last` set marks that branch in `done_mask`. `evt_done` rises at the same clock edge that presents the final branch's last word on the write port, and `busy` falls at that edge.
- R8: `start` is accepted only while idle, with `start_cpu` selecting the target. A `start` during a running event or while `evt_done` is high has no effect. `evt_ack` clears `evt_done` and returns the block to idle.
- R9: A host read (`hr_req`) whose `hr_cpu` equals the target while `busy` is high gives `hr_err` high and `hm_en` low one cycle later. Any other read gives `hm_en` high one cycle later, with `hm_cpu`/`hm_addr` copied from the request and `hr_err` low.
- R10: After reset, `busy`, `evt_done`, `done_mask`, `wr_en`, `br_ready`, `hm_en` and `hr_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load a branch region base (idle only) |
| cfg_idx | input | 3 | Branch index for the base load |
| cfg_base | input | ADDR_W | Region base address |
| start | input | 1 | Begin an event |
| start_cpu | input | 2 | Target processor for the event |
| evt_ack | input | 1 | Acknowledge event completion |
| br_valid | input | 5 | Per-branch word valid |
| br_data | input | 80 | Per-branch words, branch i in bits [16i+15:16i] |
| br_last | input | 5 | Per-branch last word of event |
| br_ready | output | 5 | Per-branch word accepted |
| wr_en | output | 1 | Target memory write strobe |
| wr_cpu | output | 2 | Processor selected for the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 16 | Write data |
| busy | output | 1 | Event readout running |
| evt_done | output | 1 | All branches finished, awaiting ack |
| done_mask | output | 5 | Branches that have sent their last word |
| hr_req | input | 1 | Host read request |
| hr_cpu | input | 2 | Processor the host wants to read |
| hr_addr | input | ADDR_W | Host read address |
| hm_en | output | 1 | Forwarded host read strobe |
| hm_cpu | output | 2 | Forwarded host read processor |
| hm_addr | output | ADDR_W | Forwarded host read address |
| hr_err | output | 1 | Host read refused (target busy) |

## Verification
`br_ready` responds within the same cycle as the inputs. The bench therefore compares it with the reference model's pick 1 ns after it drives each cycle's stimulus, before the clock edge. Write-port results, `done_mask`, `evt_done`/`busy` and the host results all change at the edge that follows their stimulus, so the bench compares them at the next falling edge against the values the model predicted for that edge. The model advances its own slot count, round-robin pointer and address counters in step with every edge. Because of this, spacing, ordering and addressing mistakes appear in the exact cycle where they occur.

// File: rtl/br_merge_pkg.sv
package br_merge_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_st_e;
endpackage

// File: rtl/br_merge_arb.sv
// Round-robin picker: first requester at or after the rotating pointer.
module br_merge_arb #(
    parameter int NUM_BR = 5,
    localparam int IDX_W = $clog2(NUM_BR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BR-1:0] req,
    output logic [NUM_BR-1:0] gnt,
    output logic [IDX_W-1:0]  gnt_idx,
    output logic              any
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_st_t;

    arb_st_t q, d;

    always_comb begin
        d       = q;
        any     = 1'b0;
        gnt_idx = '0;
        gnt     = '0;
        for (int k = 0; k < NUM_BR; k++) begin
            int c;
            c = int'(q.ptr) + k;
            if (c >= NUM_BR) c = c - NUM_BR;
            if (!any && req[c]) begin
                any     = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
        if (any) begin
            gnt[gnt_idx] = 1'b1;
            d.ptr = (int'(gnt_idx) == NUM_BR - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/br_merge_addr.sv
// Per-branch region bases and running address counters.
module br_merge_addr #(
    parameter int NUM_BR = 5,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NUM_BR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              load,
    input  logic              inc,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [ADDR_W-1:0] sel_addr
);
    typedef struct packed {
        logic [NUM_BR-1:0][ADDR_W-1:0] base;
        logic [NUM_BR-1:0][ADDR_W-1:0] cnt;
    } addr_st_t;

    addr_st_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_BR; i++) begin
            if (load) begin
                d.cnt[i] = q.base[i];
            end else if (inc && int'(sel_idx) == i) begin
                d.cnt[i] = q.cnt[i] + 1'b1;
            end
            if (cfg_we && int'(cfg_idx) == i) begin
                d.base[i] = cfg_base;
            end
        end
        sel_addr = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (int'(sel_idx) == i) sel_addr = q.cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/br_merge_host.sv
// Host read gate: refuses reads aimed at the processor being filled.
module br_merge_host #(
    parameter int CPU_W  = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [CPU_W-1:0]  tgt,
    input  logic              hr_req,
    input  logic [CPU_W-1:0]  hr_cpu,
    input  logic [ADDR_W-1:0] hr_addr,
    output logic              hm_en,
    output logic [CPU_W-1:0]  hm_cpu,
    output logic [ADDR_W-1:0] hm_addr,
    output logic              hr_err
);
    typedef struct packed {
        logic              en;
        logic              err;
        logic [CPU_W-1:0]  cpu;
        logic [ADDR_W-1:0] addr;
    } host_st_t;

    host_st_t q, d;
    logic     clash;

    always_comb begin
        d     = q;
        clash = active && (hr_cpu == tgt);
        d.en  = hr_req && !clash;
        d.err = hr_req && clash;
        if (hr_req && !clash) begin
            d.cpu  = hr_cpu;
            d.addr = hr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hm_en   = q.en;
    assign hr_err  = q.err;
    assign hm_cpu  = q.cpu;
    assign hm_addr = q.addr;
endmodule

// File: rtl/br_merge.sv
module br_merge
    import br_merge_pkg::*;
#(
    parameter int NUM_BR   = 5,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 12,
    parameter int NUM_CPU  = 3,
    parameter int SLOT_CYC = 4,
    localparam int IDX_W   = $clog2(NUM_BR),
    localparam int CPU_W   = $clog2(NUM_CPU),
    localparam int SLOT_W  = $clog2(SLOT_CYC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [ADDR_W-1:0]        cfg_base,
    input  logic                     start,
    input  logic [CPU_W-1:0]         start_cpu,
    input  logic                     evt_ack,
    input  logic [NUM_BR-1:0]        br_valid,
    input  logic [NUM_BR*DATA_W-1:0] br_data,
    input  logic [NUM_BR-1:0]        br_last,
    output logic [NUM_BR-1:0]        br_ready,
    output logic                     wr_en,
    output logic [CPU_W-1:0]         wr_cpu,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [DATA_W-1:0]        wr_data,
    output logic                     busy,
    output logic                     evt_done,
    output logic [NUM_BR-1:0]        done_mask,
    input  logic                     hr_req,
    input  logic [CPU_W-1:0]         hr_cpu,
    input  logic [ADDR_W-1:0]        hr_addr,
    output logic                     hm_en,
    output logic [CPU_W-1:0]         hm_cpu,
    output logic [ADDR_W-1:0]        hm_addr,
    output logic                     hr_err
);
    typedef struct packed {
        run_st_e           st;
        logic [CPU_W-1:0]  tgt;
        logic [NUM_BR-1:0] done;
        logic [SLOT_W-1:0] slot;
        logic              wr_en;
        logic [CPU_W-1:0]  wr_cpu;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } top_st_t;

    top_st_t q, d;

    logic              slot_free;
    logic [NUM_BR-1:0] req;
    logic [NUM_BR-1:0] gnt;
    logic [IDX_W-1:0]  gidx;
    logic              xfer;
    logic [ADDR_W-1:0] cur_addr;
    logic              evt_load;

    assign slot_free = (q.st == ST_RUN) && (q.slot == '0);
    assign req       = br_valid & ~q.done & {NUM_BR{slot_free}};
    assign evt_load  = (q.st == ST_IDLE) && start;

    br_merge_arb #(.NUM_BR(NUM_BR)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gnt     (gnt),
        .gnt_idx (gidx),
        .any     (xfer)
    );

    br_merge_addr #(.NUM_BR(NUM_BR), .ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we && (q.st == ST_IDLE)),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .load     (evt_load),
        .inc      (xfer),
        .sel_idx  (gidx),
        .sel_addr (cur_addr)
    );

    br_merge_host #(.CPU_W(CPU_W), .ADDR_W(ADDR_W)) i_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q.st == ST_RUN),
        .tgt     (q.tgt),
        .hr_req  (hr_req),
        .hr_cpu  (hr_cpu),
        .hr_addr (hr_addr),
        .hm_en   (hm_en),
        .hm_cpu  (hm_cpu),
        .hm_addr (hm_addr),
        .hr_err  (hr_err)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (q.slot != '0) d.slot = q.slot - 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_RUN;
                    d.tgt  = start_cpu;
                    d.done = '0;
                end
            end
            ST_RUN: begin
                if (xfer) begin
                    d.slot    = SLOT_W'(SLOT_CYC - 1);
                    d.wr_en   = 1'b1;
                    d.wr_cpu  = q.tgt;
                    d.wr_addr = cur_addr;
                    d.wr_data = br_data[int'(gidx)*DATA_W +: DATA_W];
                    if (br_last[gidx]) d.done[gidx] = 1'b1;
                    if (&d.done) d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (evt_ack) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign br_ready  = gnt;
    assign wr_en     = q.wr_en;
    assign wr_cpu    = q.wr_cpu;
    assign wr_addr   = q.wr_addr;
    assign wr_data   = q.wr_data;
    assign busy      = (q.st == ST_RUN);
    assign evt_done  = (q.st == ST_DONE);
    assign done_mask = q.done;
endmodule

// File: rtl/br_merge_chk.sv
module br_merge_chk #(
    parameter int NUM_BR   = 5,
    parameter int SLOT_CYC = 4,
    localparam int SW      = $clog2(SLOT_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_BR-1:0] br_valid,
    input logic [NUM_BR-1:0] br_ready,
    input logic [NUM_BR-1:0] done_mask,
    input logic              wr_en,
    input logic              busy,
    input logic              evt_done,
    input logic              evt_ack,
    input logic              hm_en,
    input logic              hr_err
);
    logic          xfer;
    logic [SW-1:0] gap_q;

    assign xfer = |(br_valid & br_ready);

    always_ff @(posedge clk) begin
        if (!rst_n)                      gap_q <= SW'(SLOT_CYC);
        else if (xfer)                   gap_q <= SW'(1);
        else if (gap_q < SW'(SLOT_CYC))  gap_q <= gap_q + 1'b1;
    end

    AST_READY_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(br_ready)); // R1
    AST_READY_VALID:    assert property (@(posedge clk) disable iff (!rst_n) (br_ready & ~br_valid) == '0); // R1
    AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (br_ready & done_mask) == '0); // R1
    AST_READY_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !busy |-> br_ready == '0); // R1
    AST_SLOT_GAP:       assert property (@(posedge clk) disable iff (!rst_n) xfer |-> gap_q >= SW'(SLOT_CYC)); // R3
    AST_WR_AFTER_XFER:  assert property (@(posedge clk) disable iff (!rst_n) xfer |=> wr_en); // R4
    AST_NO_WR_NO_XFER:  assert property (@(posedge clk) disable iff (!rst_n) !xfer |=> !wr_en); // R4
    AST_DONE_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) evt_done && !evt_ack |=> evt_done); // R8
    AST_DONE_NOT_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) !(evt_done && busy)); // R7
    AST_HOST_EXCL:      assert property (@(posedge clk) disable iff (!rst_n) !(hm_en && hr_err)); // R9
endmodule

bind br_merge br_merge_chk #(.NUM_BR(NUM_BR), .SLOT_CYC(SLOT_CYC)) i_br_merge_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .br_ready  (br_ready),
    .done_mask (done_mask),
    .wr_en     (wr_en),
    .busy      (busy),
    .evt_done  (evt_done),
    .evt_ack   (evt_ack),
    .hm_en     (hm_en),
    .hr_err    (hr_err)
);

// File: tb/test_br_merge.sv
`timescale 1ns/1ps
module test_br_merge;
    localparam int NB = 5;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int SLOT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_we = 0;
    logic [2:0]    cfg_idx = 0;
    logic [AW-1:0] cfg_base = 0;
    logic          start = 0;
    logic [1:0]    start_cpu = 0;
    logic          evt_ack = 0;
    logic [NB-1:0] br_valid = 0;
    logic [NB*DW-1:0] br_data = 0;
    logic [NB-1:0] br_last = 0;
    logic [NB-1:0] br_ready;
    logic          wr_en;
    logic [1:0]    wr_cpu;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          busy, evt_done;
    logic [NB-1:0] done_mask;
    logic          hr_req = 0;
    logic [1:0]    hr_cpu = 0;
    logic [AW-1:0] hr_addr = 0;
    logic          hm_en;
    logic [1:0]    hm_cpu;
    logic [AW-1:0] hm_addr;
    logic          hr_err;

    br_merge i_br_merge (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [16:0] srcq [NB][$];
    int src_wait [NB];
    int gap [NB];
    int m_st = 0;            // 0 idle, 1 run, 2 done
    int m_tgt = 0;
    int m_done = 0;
    int m_slot = 0;
    int m_rr = 0;
    int m_base [NB];
    int m_cnt [NB];
    int evt_no = 0;
    bit e_wr_en = 0, e_hm_en = 0, e_err = 0;
    int e_addr = 0, e_data = 0, e_cpu = 0, e_hm_cpu = 0, e_hm_addr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int pick();
        for (int k = 0; k < NB; k++) begin
            int c;
            c = (m_rr + k) % NB;
            if (m_st == 1 && m_slot == 0 && br_valid[c] && !m_done[c]) return c;
        end
        return -1;
    endfunction

    task automatic cyc();
        int p;
        for (int i = 0; i < NB; i++) begin
            br_valid[i] = (srcq[i].size() > 0) && (src_wait[i] == 0);
            br_data[i*DW +: DW] = br_valid[i] ? srcq[i][0][15:0] : '0;
            br_last[i] = br_valid[i] ? srcq[i][0][16] : 1'b0;
        end
        #1;
        p = pick();
        chk("R1 R2 ready", 32'(br_ready), (p >= 0) ? (32'd1 << p) : 32'd0);
        // host path prediction
        e_err   = hr_req && m_st == 1 && int'(hr_cpu) == m_tgt;
        e_hm_en = hr_req && !e_err;
        if (e_hm_en) begin e_hm_cpu = hr_cpu; e_hm_addr = hr_addr; end
        e_wr_en = 0;
        if (m_slot > 0) m_slot--;
        for (int i = 0; i < NB; i++) if (i != p && src_wait[i] > 0) src_wait[i]--;
        case (m_st)
            0: begin
                if (start) begin
                    m_st = 1; m_tgt = start_cpu; m_done = 0;
                    for (int i = 0; i < NB; i++) m_cnt[i] = m_base[i];
                end
                if (cfg_we && cfg_idx < NB) m_base[cfg_idx] = cfg_base;
            end
            1: if (p >= 0) begin
                e_wr_en = 1;
                e_addr = m_cnt[p];
                e_data = srcq[p][0][15:0];
                e_cpu = m_tgt;
                m_cnt[p] = (m_cnt[p] + 1) % (1 << AW);
                if (srcq[p][0][16]) m_done = m_done | (1 << p);
                void'(srcq[p].pop_front());
                src_wait[p] = gap[p];
                m_rr = (p + 1) % NB;
                m_slot = SLOT - 1;
                if (m_done == (1 << NB) - 1) m_st = 2;
            end
            default: if (evt_ack) m_st = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        start = 0; cfg_we = 0; evt_ack = 0; hr_req = 0;
        chk("R3 R4 wr_en", 32'(wr_en), 32'(e_wr_en));
        if (e_wr_en) begin
            chk("R4 wr_data", 32'(wr_data), e_data);
            chk("R4 wr_cpu", 32'(wr_cpu), e_cpu);
            chk(evt_no >= 2 ? "R5 R6 wr_addr" : "R5 wr_addr", 32'(wr_addr), e_addr);
        end
        chk("R7 done_mask", 32'(done_mask), m_done);
        chk("R7 R8 evt_done", 32'(evt_done), 32'(m_st == 2));
        chk("R7 R8 busy", 32'(busy), 32'(m_st == 1));
        chk("R9 hm_en", 32'(hm_en), 32'(e_hm_en));
        chk("R9 hr_err", 32'(hr_err), 32'(e_err));
        if (e_hm_en) begin
            chk("R9 hm_cpu", 32'(hm_cpu), e_hm_cpu);
            chk("R9 hm_addr", 32'(hm_addr), e_hm_addr);
        end
    endtask

    task automatic load_branch(input int b, input int n, input int g);
        gap[b] = g;
        for (int j = 0; j < n; j++) srcq[b].push_back({(j == n - 1), 16'(b * 4096 + evt_no * 256 + j)});
    endtask

    // run an event to completion with host reads sprinkled in
    task automatic run_event(input bit stray_start, input bit stray_cfg);
        int n = 0;
        while (m_st != 2 && n < 3000) begin
            if (n % 5 == 2) begin hr_req = 1; hr_cpu = 2'(n % 3); hr_addr = AW'(n); end
            if (stray_start && n == 3) begin start = 1; start_cpu = 2; end        // R8 ignored
            if (stray_cfg && n == 4) begin cfg_we = 1; cfg_idx = 2; cfg_base = 12'h7F0; end // R6 ignored
            cyc();
            n++;
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin src_wait[i] = 0; gap[i] = 0; m_base[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R10 reset state
        chk("R10 busy", 32'(busy), 0);
        chk("R10 evt_done", 32'(evt_done), 0);
        chk("R10 done_mask", 32'(done_mask), 0);
        chk("R10 wr_en", 32'(wr_en), 0);
        chk("R10 br_ready", 32'(br_ready), 0);
        chk("R10 hm_en", 32'(hm_en), 0);
        chk("R10 hr_err", 32'(hr_err), 0);
        @(negedge clk);
        // R6 bases in idle
        for (int b = 0; b < NB; b++) begin
            cfg_we = 1; cfg_idx = 3'(b); cfg_base = AW'(b * 256); cyc();
        end
        // event 1: paced branches of differing lengths, target 1
        evt_no = 1;
        for (int b = 0; b < NB; b++) load_branch(b, 3 + b, b * 3);
        start = 1; start_cpu = 1; cyc();
        run_event(1'b0, 1'b0);
        // R8 start while done is ignored
        start = 1; start_cpu = 0; cyc();
        repeat (3) cyc();
        evt_ack = 1; cyc();
        cyc();
        // event 2: full contention, stray start and cfg during run, target 0
        evt_no = 2;
        load_branch(0, 9, 0); load_branch(1, 1, 0); load_branch(2, 2, 0);
        load_branch(3, 1, 0); load_branch(4, 5, 0);
        srcq[3].push_back({1'b0, 16'hDEAD});  // offered after last: R1 must not take it
        start = 1; start_cpu = 0; cyc();
        run_event(1'b1, 1'b1);
        repeat (4) cyc();
        evt_ack = 1; cyc();
        // event 3: new base for branch 2 loaded while idle, target 2
        evt_no = 3;
        cfg_we = 1; cfg_idx = 2; cfg_base = 12'hFFE; cyc();
        srcq[3].delete();
        for (int b = 0; b < NB; b++) load_branch(b, (b == 2) ? 4 : 1, 1);
        start = 1; start_cpu = 2; cyc();
        run_event(1'b0, 1'b0);
        evt_ack = 1; cyc();
        repeat (2) cyc();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule